// File: doc/BRIEF.md
# Register Pointer Front End for a Power-Management Companion

This block sits between a byte-level serial slave shim and the configuration registers of a power-management companion device. The shim presents three decoded events, each for one clock cycle: the start of a write transfer, a received byte, and a request for the next byte to send. The block keeps an 8-bit register pointer. After a write start, the first received byte sets the pointer. Each byte after it is stored at the pointer, and the pointer then advances. Each read request returns the register at the pointer and advances the pointer.

Stored values pass through a per-register field mask. Two core-voltage selectors clamp their 5-bit field to a ceiling. A fixed revision location is read-only. A command location reloads every register with its reset value. The oscillator control location stores three bits and reports a clock-good flag in bit 7 on reads.

Top module: `pmic_regif`

## Requirements
- R1: A start-of-write event arms an address phase. The next received byte loads the pointer and is not written to any register. Reset clears the address phase.
- R2: Each received byte outside the address phase is written to the register at the pointer, and the pointer then increments by one.
- R3: The read byte shows the register at the current pointer in the same cycle as the read request. The pointer increments by one after each read request.
- R4: The pointer wraps from 0xFF to 0x00 on both reads and writes.
- R5: Address 0x01 always reads 0x22, and writes to it have no effect.
- R6: A write to address 0x14 with bit 0 set returns every register to its reset value. A write to 0x14 with bit 0 clear changes nothing. Address 0x14 reads 0x00.
- R7: At addresses 0x04 and 0x05, a write stores the smaller of (value AND 0x1F) and 0x12.
- R8: Address 0x15 keeps only bits 2:0 of a write. A read of 0x15 returns those bits with bit 7 set.
- R9: Writes are masked per register:
  - 0x02, 0x03, 0x12 and 0x13 keep all 8 bits.
  - 0x06 keeps bits 1:0.
  - 0x07 keeps bits 5:0.
  - 0x16 keeps bits 6:0.
- R10: Any address outside 0x01–0x07, 0x12–0x16 reads 0x00, and writes to it have no effect.
- R11: After reset, the pointer is 0x00 and the registers hold these values:
  - 0x02 = 0x0C, 0x03 = 0x05, 0x04 = 0x02, 0x05 = 0x0C
  - 0x06 = 0x03, 0x07 = 0x33
  - 0x12 = 0x00, 0x13 = 0x00
  - 0x15 = 0x01, 0x16 = 0x09

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start_i | input | 1 | One-cycle pulse at the start of a write transfer |
| rx_valid_i | input | 1 | A received byte is on rx_byte_i this cycle |
| rx_byte_i | input | 8 | Received byte (address or data) |
| rd_req_i | input | 1 | The shim takes a byte this cycle |
| rd_byte_o | output | 8 | Register value at the pointer, valid combinationally |

## Verification
The hardest case to reach is a full soft reset. The stimulus must first move several registers away from their reset values, including the clamped selectors and the oscillator field. It must then show that a 0x14 write with bit 0 clear leaves them alone, and that a write with bit 0 set restores them all. The bench also loads the pointer with 0xFF and then streams bytes and reads across the boundary, which exercises the wrap on both paths. To show that the address byte is never stored, the bench addresses a register that already holds a known value and then reads it back.

// File: rtl/pmic_regif_pkg.sv
package pmic_regif_pkg;

   localparam int BYTE_W     = 8;
   localparam int NUM_ENTRIES = 10;

   typedef logic [BYTE_W-1:0] byte_t;

   typedef struct packed {
      logic [BYTE_W-1:0] addr;    // location in the pointer space
      logic [BYTE_W-1:0] wmask;   // bits kept on write
      logic [BYTE_W-1:0] rstv;    // value after reset or soft reset
      logic              clamp;   // use clamped field instead of mask
      logic [BYTE_W-1:0] rdset;   // bits forced high on read
   } reg_desc_t;

   localparam reg_desc_t REG_TABLE [NUM_ENTRIES] = '{
      '{8'h02, 8'hFF, 8'h0C, 1'b0, 8'h00},
      '{8'h03, 8'hFF, 8'h05, 1'b0, 8'h00},
      '{8'h04, 8'h1F, 8'h02, 1'b1, 8'h00},
      '{8'h05, 8'h1F, 8'h0C, 1'b1, 8'h00},
      '{8'h06, 8'h03, 8'h03, 1'b0, 8'h00},
      '{8'h07, 8'h3F, 8'h33, 1'b0, 8'h00},
      '{8'h12, 8'hFF, 8'h00, 1'b0, 8'h00},
      '{8'h13, 8'hFF, 8'h00, 1'b0, 8'h00},
      '{8'h15, 8'h07, 8'h01, 1'b0, 8'h80},
      '{8'h16, 8'h7F, 8'h09, 1'b0, 8'h00}
   };

endpackage

// File: rtl/regif_ptr.sv
module regif_ptr
   import pmic_regif_pkg::*;
#(
   parameter int AW = BYTE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          byte_vld_i,
   input  logic [AW-1:0] byte_i,
   input  logic          rd_req_i,
   output logic [AW-1:0] ptr_o,
   output logic          wr_en_o
);

   localparam logic [AW-1:0] PTR_ONE = AW'(1);

   logic          addr_phase_q;
   logic [AW-1:0] ptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_phase_q <= 1'b0;
         ptr_q        <= '0;
      end else if (start_i) begin
         addr_phase_q <= 1'b1;
      end else if (byte_vld_i) begin
         if (addr_phase_q) begin
            ptr_q        <= byte_i;
            addr_phase_q <= 1'b0;
         end else begin
            ptr_q <= ptr_q + PTR_ONE;
         end
      end else if (rd_req_i) begin
         ptr_q <= ptr_q + PTR_ONE;
      end
   end

   assign ptr_o   = ptr_q;
   assign wr_en_o = byte_vld_i & ~addr_phase_q & ~start_i;

   assert_one_event_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({start_i, byte_vld_i, rd_req_i}) <= 1);

   assert_addr_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld_i && !wr_en_o && !start_i) |=> (ptr_q == $past(byte_i)));

   assert_write_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |=> (ptr_q == $past(ptr_q) + PTR_ONE));

   assert_read_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_i && !start_i && !byte_vld_i) |=> (ptr_q == $past(ptr_q) + PTR_ONE));

   assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_req_i || wr_en_o) && !start_i && (ptr_q == '1)) |=> (ptr_q == '0));

endmodule

// File: rtl/regif_wrfmt.sv
module regif_wrfmt
   import pmic_regif_pkg::*;
#(
   parameter logic [BYTE_W-1:0] WMASK       = 8'hFF,
   parameter bit                CLAMP_EN    = 1'b0,
   parameter logic [BYTE_W-1:0] CLAMP_FIELD = 8'h1F,
   parameter logic [BYTE_W-1:0] CLAMP_LIMIT = 8'h12
) (
   input  logic [BYTE_W-1:0] din,
   output logic [BYTE_W-1:0] dout
);

   if (CLAMP_LIMIT > CLAMP_FIELD) begin : g_bad_limit
      $error("clamp ceiling exceeds the field it limits");
   end

   if (CLAMP_EN) begin : g_clamp
      logic [BYTE_W-1:0] field;
      assign field = din & CLAMP_FIELD;
      assign dout  = (field > CLAMP_LIMIT) ? CLAMP_LIMIT : field;
   end else begin : g_mask
      assign dout = din & WMASK;
   end

endmodule

// File: rtl/regif_regfile.sv
module regif_regfile
   import pmic_regif_pkg::*;
#(
   parameter int                NUM         = NUM_ENTRIES,
   parameter logic [BYTE_W-1:0] CLAMP_FIELD = 8'h1F,
   parameter logic [BYTE_W-1:0] CLAMP_LIMIT = 8'h12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [BYTE_W-1:0] wr_addr_i,
   input  logic [BYTE_W-1:0] wr_data_i,
   input  logic              soft_rst_i,
   input  logic [BYTE_W-1:0] rd_addr_i,
   output logic [BYTE_W-1:0] rd_data_o
);

   if (NUM > NUM_ENTRIES || NUM < 1) begin : g_bad_num
      $error("entry count outside the register table");
   end

   logic [BYTE_W-1:0] q_all [NUM];

   for (genvar i = 0; i < NUM; i++) begin : g_ent
      localparam reg_desc_t D = REG_TABLE[i];
      logic [BYTE_W-1:0] q_r;
      logic [BYTE_W-1:0] fmt;

      regif_wrfmt #(
         .WMASK       (D.wmask),
         .CLAMP_EN    (D.clamp),
         .CLAMP_FIELD (CLAMP_FIELD),
         .CLAMP_LIMIT (CLAMP_LIMIT)
      ) u_fmt (
         .din  (wr_data_i),
         .dout (fmt)
      );

      always_ff @(posedge clk) begin
         if (!rst_n || soft_rst_i) begin
            q_r <= D.rstv;
         end else if (wr_en_i && (wr_addr_i == D.addr)) begin
            q_r <= fmt;
         end
      end

      assign q_all[i] = q_r;

      assert_soft_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
         soft_rst_i |=> (q_r == D.rstv));

      if (D.clamp) begin : g_chk_clamp
         assert_clamp_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (q_r <= CLAMP_LIMIT));
      end else begin : g_chk_mask
         assert_field_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ((q_r & ~D.wmask) == (D.rstv & ~D.wmask)));
      end
   end

   always_comb begin
      rd_data_o = '0;
      for (int i = 0; i < NUM; i++) begin
         if (rd_addr_i == REG_TABLE[i].addr) begin
            rd_data_o = rd_data_o | q_all[i] | REG_TABLE[i].rdset;
         end
      end
   end

endmodule

// File: rtl/pmic_regif.sv
module pmic_regif
   import pmic_regif_pkg::*;
#(
   parameter logic [BYTE_W-1:0] REV_ADDR    = 8'h01,
   parameter logic [BYTE_W-1:0] REV_VALUE   = 8'h22,
   parameter logic [BYTE_W-1:0] SRST_ADDR   = 8'h14,
   parameter logic [BYTE_W-1:0] OSC_ADDR    = 8'h15,
   parameter logic [BYTE_W-1:0] CLAMP_FIELD = 8'h1F,
   parameter logic [BYTE_W-1:0] CLAMP_LIMIT = 8'h12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_start_i,
   input  logic              rx_valid_i,
   input  logic [BYTE_W-1:0] rx_byte_i,
   input  logic              rd_req_i,
   output logic [BYTE_W-1:0] rd_byte_o
);

   if (REV_ADDR == SRST_ADDR) begin : g_bad_map
      $error("revision and soft-reset locations collide");
   end

   logic [BYTE_W-1:0] ptr;
   logic              wr_en;
   logic              soft_rst;
   logic [BYTE_W-1:0] file_rd;

   regif_ptr #(.AW(BYTE_W)) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (wr_start_i),
      .byte_vld_i (rx_valid_i),
      .byte_i     (rx_byte_i),
      .rd_req_i   (rd_req_i),
      .ptr_o      (ptr),
      .wr_en_o    (wr_en)
   );

   assign soft_rst = wr_en && (ptr == SRST_ADDR) && rx_byte_i[0];

   regif_regfile #(
      .NUM         (NUM_ENTRIES),
      .CLAMP_FIELD (CLAMP_FIELD),
      .CLAMP_LIMIT (CLAMP_LIMIT)
   ) u_rf (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (wr_en),
      .wr_addr_i  (ptr),
      .wr_data_i  (rx_byte_i),
      .soft_rst_i (soft_rst),
      .rd_addr_i  (ptr),
      .rd_data_o  (file_rd)
   );

   assign rd_byte_o = (ptr == REV_ADDR) ? REV_VALUE : file_rd;

   assert_clk_good_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_i && ptr == OSC_ADDR) |-> rd_byte_o[7]);

   assert_srst_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_i && ptr == SRST_ADDR) |-> (rd_byte_o == '0));

endmodule

// File: tb/pmic_regif_bench.sv
module pmic_regif_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_start_i = 1'b0;
   logic       rx_valid_i = 1'b0;
   logic [7:0] rx_byte_i = '0;
   logic       rd_req_i = 1'b0;
   logic [7:0] rd_byte_o;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   logic [7:0] exp_q [$];
   string      tag_q [$];

   always #2.5 clk = ~clk;

   pmic_regif u_pmic_regif (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_start_i (wr_start_i),
      .rx_valid_i (rx_valid_i),
      .rx_byte_i  (rx_byte_i),
      .rd_req_i   (rd_req_i),
      .rd_byte_o  (rd_byte_o)
   );

   // monitor: compares each read byte with the head of the scoreboard
   always @(negedge clk) begin
      if (rst_n && rd_req_i) begin
         total++;
         if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL unexpected read: actual=%02h expected=none", rd_byte_o);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rd_byte_o !== e) begin
               bad++;
               $display("FAIL %s: actual=%02h expected=%02h", t, rd_byte_o, e);
            end
         end
      end
   end

   task automatic pulse_start();
      @(posedge clk); #1;
      wr_start_i = 1'b1;
      @(posedge clk); #1;
      wr_start_i = 1'b0;
   endtask

   task automatic send(input logic [7:0] b);
      @(posedge clk); #1;
      rx_valid_i = 1'b1;
      rx_byte_i  = b;
      @(posedge clk); #1;
      rx_valid_i = 1'b0;
   endtask

   task automatic point(input logic [7:0] a);
      pulse_start();
      send(a);
   endtask

   task automatic rd(input logic [7:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(posedge clk); #1;
      rd_req_i = 1'b1;
      @(posedge clk); #1;
      rd_req_i = 1'b0;
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;

      // R11 / R1: address phase clear after reset, byte writes unmapped 0x00
      send(8'hAA);
      rd(8'h22, "R1 no address phase after reset, R5 rev");
      rd(8'h0C, "R11 reset 0x02");
      rd(8'h05, "R11 reset 0x03");
      rd(8'h02, "R11 reset 0x04");
      rd(8'h0C, "R11 reset 0x05");
      rd(8'h03, "R11 reset 0x06");
      rd(8'h33, "R11 reset 0x07");
      point(8'h12);
      rd(8'h00, "R11 reset 0x12");
      point(8'h15);
      rd(8'h81, "R11 reset 0x15 with R8 flag");
      rd(8'h09, "R11 reset 0x16");

      // R2 / R9 / R7: burst write then burst read
      point(8'h02);
      send(8'hA5); send(8'hFF); send(8'h1F);
      send(8'h0D); send(8'hFF); send(8'hFF);
      point(8'h02);
      rd(8'hA5, "R2 burst 0x02");
      rd(8'hFF, "R9 full 0x03");
      rd(8'h12, "R7 clamp 0x04");
      rd(8'h0D, "R7 below ceiling 0x05");
      rd(8'h03, "R9 mask 0x06");
      rd(8'h3F, "R9 mask 0x07");

      point(8'h04);
      send(8'hF1); send(8'h13);
      point(8'h04);
      rd(8'h11, "R7 upper bits dropped 0x04");
      rd(8'h12, "R7 clamp 0x05");

      // R1: address byte is never stored
      point(8'h12);
      send(8'h11); send(8'h5A);
      point(8'h13);
      point(8'h12);
      rd(8'h11, "R1 0x12 kept");
      rd(8'h5A, "R1 address byte not stored in 0x13");

      // R5 revision read-only
      point(8'h01);
      send(8'h00);
      point(8'h01);
      rd(8'h22, "R5 revision after write");

      // R8 / R9 oscillator and detect
      point(8'h15);
      send(8'hFE); send(8'hFF);
      point(8'h15);
      rd(8'h86, "R8 three bits plus flag");
      rd(8'h7F, "R9 mask 0x16");

      // R10 unmapped
      point(8'h40);
      send(8'h77);
      point(8'h40);
      rd(8'h00, "R10 unmapped 0x40");
      rd(8'h00, "R10 unmapped 0x41");

      // R4 wrap on reads and writes
      point(8'hFF);
      rd(8'h00, "R4 read 0xFF");
      rd(8'h00, "R4 read 0x00 after wrap");
      rd(8'h22, "R4 read 0x01 after wrap");
      point(8'hFF);
      send(8'h99); send(8'h98);
      rd(8'h22, "R4 pointer at 0x01 after write wrap");

      // R6 soft reset: bit 0 clear does nothing
      point(8'h14);
      send(8'hFE);
      point(8'h14);
      rd(8'h00, "R6 0x14 reads zero");
      rd(8'h86, "R6 bit0 clear keeps 0x15");
      // bit 0 set restores everything
      point(8'h14);
      send(8'h01);
      point(8'h02);
      rd(8'h0C, "R6 restore 0x02");
      rd(8'h05, "R6 restore 0x03");
      rd(8'h02, "R6 restore 0x04");
      rd(8'h0C, "R6 restore 0x05");
      rd(8'h03, "R6 restore 0x06");
      rd(8'h33, "R6 restore 0x07");
      point(8'h12);
      rd(8'h00, "R6 restore 0x12");
      rd(8'h00, "R6 restore 0x13");
      point(8'h15);
      rd(8'h81, "R6 restore 0x15");
      rd(8'h09, "R6 restore 0x16");

      repeat (3) @(posedge clk);
      if (exp_q.size() != 0) begin
         total++; bad++;
         $display("FAIL R3 reads missing: actual=%0d expected=0 left", exp_q.size());
      end
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog R3: actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule